// File: doc/BRIEF.md
# Watchdog Timer with Timeout Mode

This block is a 16-bit up-counting watchdog that guards the window in which software holds protected configuration open. Whenever it enters timeout mode, whether on reset or because software clears the end-of-initialization flag, the count is loaded three steps short of its top value. If the count then passes 16'hFFFF before software sets the flag again, the block raises a one-cycle reset-request pulse and freezes until reset.

The count advances on ticks from a free-running 14-bit prescaler. The active rate bit selects the divide ratio: 0 gives one tick per 16384 clocks and 1 gives one tick per 256 clocks. A requested rate is latched into the active rate bit only when software sets the end-of-initialization flag. Loading the count does not restart the prescaler, so a timeout entered during operation lasts between three and four ticks. After reset the prescaler and the count start together, so the first timeout always lasts four full ticks.

Top module: `wdt_timeout`

## Requirements
- R1: While rst_ni is low, tmo_mode_o is 1, count_o is 16'hFFFC, rate_o is 0 and ovf_o is 0.
- R2: The prescaler counts every clock and wraps at 16384. A tick occurs on clocks where all 14 prescaler bits are one when rate_o is 0, and where the low 8 bits are one when rate_o is 1.
- R3: With no writes after reset, ovf_o goes high exactly at the 65536th rising edge after rst_ni is released.
- R4: In timeout mode, each tick raises count_o by one. In normal mode (tmo_mode_o = 0), count_o holds its value.
- R5: A tick while count_o is 16'hFFFF in timeout mode wraps count_o to 16'h0000 and drives ovf_o high for exactly one cycle.
- R6: After an overflow, count_o stays 16'h0000, tmo_mode_o stays 1 and every write is ignored until reset.
- R7: A write (endinit_we_i = 1) with endinit_i = 1 clears tmo_mode_o and copies rate_req_i into rate_o at the same edge. No overflow occurs while tmo_mode_o is 0.
- R8: rate_req_i has no effect on rate_o or on the tick rate except through an R7 write.
- R9: A write with endinit_i = 0 sets tmo_mode_o and loads count_o with 16'hFFFC at the same edge, even when a tick falls on that edge. The prescaler is not restarted.
- R10: With rate_o = 1, a timeout entered on the edge just before a tick overflows 769 edges after entry (three ticks). A timeout entered on a tick edge overflows after 1024 edges (four ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| endinit_we_i | input | 1 | Write strobe for the end-of-initialization flag |
| endinit_i | input | 1 | Value written to the flag (1 exits and 0 enters timeout mode) |
| rate_req_i | input | 1 | Requested rate select, latched on exit |
| tmo_mode_o | output | 1 | Timeout mode active |
| count_o | output | 16 | Current watchdog count |
| rate_o | output | 1 | Active rate select (0 = /16384, 1 = /256) |
| ovf_o | output | 1 | One-cycle overflow / reset-request pulse |

## Verification
All outputs are registered. A write changes tmo_mode_o, rate_o and count_o at the rising edge on which the strobe is sampled. A tick on edge N changes count_o at edge N, and an overflow raises ovf_o at that same edge for one cycle. The bench drives inputs at falling edges and updates its behavioural model once per rising edge. It compares every output at the following falling edge, so each result is checked in the cycle it is due. The timeout lengths (65536, 769 and 1024 edges) are counted in edges from the entry edge to the first high ovf_o.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic enter;  // clear flag: (re)enter timeout mode
    logic leave;  // set flag: proper exit
  } wdt_cmd_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PSC_W  = 14,
  parameter int unsigned FAST_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  logic [PSC_W-1:0] psc_q;

  // free running, never resynchronized to mode changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_q + 1'b1;
  end

  generate
    if (FAST_W < PSC_W) begin : g_two_rate
      assign tick_o = fast_i ? (&psc_q[FAST_W-1:0]) : (&psc_q);
    end else begin : g_one_rate
      logic unused_fast;
      assign unused_fast = fast_i;
      assign tick_o      = &psc_q;
    end
  endgenerate
endmodule

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     endinit_i,
  input  logic     rate_req_i,
  input  logic     wrap_i,
  output wdt_cmd_t cmd_o,
  output logic     tmo_o,
  output logic     rate_o,
  output logic     expired_o
);
  logic tmo_q, rate_q, exp_q;

  always_comb begin
    cmd_o.leave = we_i &  endinit_i & ~exp_q;
    cmd_o.enter = we_i & ~endinit_i & ~exp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= 1'b1;
      rate_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      if (cmd_o.leave) begin
        tmo_q  <= 1'b0;
        rate_q <= rate_req_i;  // deferred rate latch
      end else if (cmd_o.enter) begin
        tmo_q  <= 1'b1;
      end
      if (wrap_i) exp_q <= 1'b1;
    end
  end

  assign tmo_o     = tmo_q;
  assign rate_o    = rate_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wdt_cmd_t         cmd_i,
  input  logic             tmo_i,
  input  logic             expired_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = {CNT_W{1'b1}} - CNT_W'(3);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             run;

  assign run    = tmo_i & ~expired_i & ~cmd_i.enter & ~cmd_i.leave;
  assign wrap_o = run & tick_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_VAL;
      ovf_q <= 1'b0;
    end else begin
      if (cmd_i.enter)        cnt_q <= LOAD_VAL;
      else if (run && tick_i) cnt_q <= cnt_q + 1'b1;
      ovf_q <= wrap_o;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 14,
  parameter int unsigned FAST_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             endinit_we_i,
  input  logic             endinit_i,
  input  logic             rate_req_i,
  output logic             tmo_mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rate_o,
  output logic             ovf_o
);
  wdt_cmd_t cmd;
  logic     tick, wrap, expired;

  wdt_prescaler #(.PSC_W(PSC_W), .FAST_W(FAST_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (rate_o),
    .tick_o (tick)
  );

  wdt_mode_ctrl i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (endinit_we_i),
    .endinit_i  (endinit_i),
    .rate_req_i (rate_req_i),
    .wrap_i     (wrap),
    .cmd_o      (cmd),
    .tmo_o      (tmo_mode_o),
    .rate_o     (rate_o),
    .expired_o  (expired)
  );

  wdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .tmo_i     (tmo_mode_o),
    .expired_i (expired),
    .tick_i    (tick),
    .count_o   (count_o),
    .wrap_o    (wrap),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/wdt_timeout_chk.sv
module wdt_timeout_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             endinit_we_i,
  input logic             endinit_i,
  input logic             tmo_mode_o,
  input logic [CNT_W-1:0] count_o,
  input logic             rate_o,
  input logic             ovf_o,
  input logic             expired_i
);
  localparam logic [CNT_W-1:0] LOAD_VAL = {CNT_W{1'b1}} - CNT_W'(3);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  a_r5_wrap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_o == '0) && ($past(count_o) == '1));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_i |=> (count_o == '0) && tmo_mode_o && !ovf_o);

  a_r7_no_ovf_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo_mode_o |=> !ovf_o);

  a_r8_rate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(endinit_we_i && endinit_i) |=> $stable(rate_o));

  a_r9_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (endinit_we_i && !endinit_i && !expired_i) |=> (count_o == LOAD_VAL) && tmo_mode_o);

  a_r4_hold_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_mode_o && !endinit_we_i) |=> $stable(count_o));
endmodule

bind wdt_timeout wdt_timeout_chk #(.CNT_W(CNT_W)) i_wdt_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .endinit_we_i (endinit_we_i),
  .endinit_i    (endinit_i),
  .tmo_mode_o   (tmo_mode_o),
  .count_o      (count_o),
  .rate_o       (rate_o),
  .ovf_o        (ovf_o),
  .expired_i    (expired)
);

// File: tb/test_wdt_timeout.sv
`timescale 1ns/1ps
module test_wdt_timeout;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        endinit_we_i = 1'b0;
  logic        endinit_i = 1'b0;
  logic        rate_req_i = 1'b0;
  logic        tmo_mode_o;
  logic [15:0] count_o;
  logic        rate_o;
  logic        ovf_o;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  int m_psc, m_cnt, m_tmo, m_rate, m_exp, m_ovf;

  always #2 clk_i = ~clk_i;

  wdt_timeout i_wdt_timeout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .endinit_we_i (endinit_we_i),
    .endinit_i    (endinit_i),
    .rate_req_i   (rate_req_i),
    .tmo_mode_o   (tmo_mode_o),
    .count_o      (count_o),
    .rate_o       (rate_o),
    .ovf_o        (ovf_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    m_psc = 0; m_cnt = 'hFFFC; m_tmo = 1; m_rate = 0; m_exp = 0; m_ovf = 0;
  endtask

  task automatic model_edge(bit we, bit val, bit req);
    bit tick;
    tick  = m_rate ? ((m_psc % 256) == 255) : (m_psc == 16383);
    m_ovf = 0;
    if (m_exp == 0) begin
      if (we && val) begin
        m_tmo = 0; m_rate = int'(req);
      end else if (we && !val) begin
        m_tmo = 1; m_cnt = 'hFFFC;
      end else if (m_tmo == 1 && tick) begin
        if (m_cnt == 'hFFFF) begin
          m_cnt = 0; m_ovf = 1; m_exp = 1;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
    m_psc = (m_psc + 1) % 16384;
  endtask

  task automatic step(bit we, bit val, bit req);
    endinit_we_i = we;
    endinit_i    = val;
    rate_req_i   = req;
    @(posedge clk_i);
    model_edge(we, val, req);
    @(negedge clk_i);
    chk("R4/R9 count_o", int'(count_o), m_cnt);
    chk("R7/R9 tmo_mode_o", int'(tmo_mode_o), m_tmo);
    chk("R8 rate_o", int'(rate_o), m_rate);
    chk("R5 ovf_o", int'(ovf_o), m_ovf);
  endtask

  task automatic run_until_ovf(bit req, int limit, output int n);
    n = 0;
    do begin
      step(1'b0, 1'b0, req);
      n++;
    end while (!ovf_o && n < limit);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    endinit_we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset tmo_mode_o", int'(tmo_mode_o), 1);
    chk("R1 reset count_o", int'(count_o), 'hFFFC);
    chk("R1 reset rate_o", int'(rate_o), 0);
    chk("R1 reset ovf_o", int'(ovf_o), 0);
    model_init();
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;

    // post-reset timeout, rate request alone must not apply (R3, R8, R2)
    do_reset();
    run_until_ovf(1'b1, 70000, n);
    chk("R3 post-reset timeout edges", n, 65536);
    chk("R8 rate_o held without exit", int'(rate_o), 0);
    step(1'b0, 1'b0, 1'b1);
    chk("R5 ovf_o single cycle", int'(ovf_o), 0);
    step(1'b1, 1'b1, 1'b1);
    chk("R6 exit ignored tmo_mode_o", int'(tmo_mode_o), 1);
    chk("R6 exit ignored rate_o", int'(rate_o), 0);
    step(1'b1, 1'b0, 1'b0);
    chk("R6 enter ignored count_o", int'(count_o), 0);

    // proper exit with deferred rate latch (R7, R4)
    do_reset();
    repeat (100) step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R7 exit tmo_mode_o", int'(tmo_mode_o), 0);
    chk("R7 exit rate_o latched", int'(rate_o), 1);
    repeat (300) step(1'b0, 1'b0, 1'b0);
    chk("R4 count held in normal mode", int'(count_o), 'hFFFC);
    chk("R8 rate_o unchanged by request", int'(rate_o), 1);

    // minimum timeout: enter one edge before a tick (R9, R10)
    while ((m_psc % 256) != 254) step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R9 reload count_o", int'(count_o), 'hFFFC);
    chk("R8 rate_o kept on entry", int'(rate_o), 1);
    run_until_ovf(1'b0, 2000, n);
    chk("R10 minimum timeout edges", n, 769);

    // maximum timeout: enter on a tick edge (R9 priority, R10)
    do_reset();
    step(1'b1, 1'b1, 1'b1);
    while ((m_psc % 256) != 255) step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R9 load beats tick", int'(count_o), 'hFFFC);
    run_until_ovf(1'b1, 2000, n);
    chk("R10 maximum timeout edges", n, 1024);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule